// File: doc/BRIEF.md
# Bridge Function-0 Configuration Header

This block holds the function-0 configuration header of a PCI-to-ISA bridge. It is reached from the host through the two-port configuration access scheme. A 32-bit write to the address port loads a latch holding an enable flag, a bus number, a device number, a function number and a dword register index. A later access to the data port then reads or writes the selected header dword. Byte enables pick which bytes of that dword a write updates.

The header holds several kinds of field:
- read-only identification fields and class codes;
- a command word in which three bits trade their access type under a test bit;
- a status word whose event flags are set by hardware inputs and cleared by writing one;
- a subsystem identifier that is read-only in the header but loaded through a separate writable alias dword;
- two plain storage bytes for ISA bus control and ISA test settings.

The block does no bus signalling and runs no ISA cycles. It only stores the register state and returns it.

Top module: `bridge_cfg_header`

## Requirements
- R1: An address-port write stores bit 31 (enable), bits 23:16 (bus), bits 15:11 (device), bits 10:8 (function) and bits 7:2 (dword index), each byte only when its byte enable is set. An address-port read returns the stored fields with bits 30:24 and 1:0 reading 0. The latch resets to 0.
- R2: A data-port access is accepted only when the latch enable is 1, the bus and device match the `BUS_NUM` and `DEV_NUM` parameters, and the function is 0. Otherwise a read returns FFFFFFFFh and a write changes nothing.
- R3: The identification dwords are read-only and ignore writes:
  - dword 0 reads {`DEVICE_ID`, `VENDOR_ID`};
  - dword 2 reads {06h, 01h, 00h, `REVISION_ID`};
  - dword 3 reads 0080_0000h, which gives header type 80h in byte 2 and 00h in byte 3.
- R4: In the command word (dword 1, bits 15:0), bits 15:8 and 6:4 read 0 and bit 2 reads 1. Bit 7 is read/write and resets to 1.
- R5: While the test bit is 0, command bits 1:0 read 11b and ignore writes. Bit 3 is read/write and resets to 0.
- R6: While the test bit is 1, command bit 3 reads 1 and ignores writes. Bits 1:0 are read/write, keep their stored value and reset to 11b.
- R7: In the status word (dword 1, bits 31:16), status bits 10:9 read 01b. Status bits 14, 8 and 7:0 read 0.
- R8: Status bits 15, 13, 12 and 11 are set by the parity-error, master-abort-received, target-abort-received and target-abort-signalled inputs, in that order. They sit at dword bits 31, 29, 28 and 27. Writing 1 to such a bit with byte enable 3 set clears it. Writing 0 leaves it unchanged.
- R9: If an event input and a clearing write hit the same flag in the same cycle, the flag ends set.
- R10: The subsystem dword (index 0Bh) is read-only. Writes to the alias dword (index 1Ch) set, byte by byte, the value that both dwords return. That value resets to `SUBSYS_RESET`.
- R11: Dword 10h holds two read/write bytes: ISA control in byte 0 and ISA test in byte 1. Both reset to 00h, and bytes 3:2 read 0. Across the whole header, a write touches only the bytes whose enables are set.
- R12: The test bit is bit 4 of byte 2 of dword 11h, which is dword bit 20. It resets to 0. All other bits of dword 11h read 0.
- R13: Any dword index not listed above reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrite | input | 1 | Host write strobe, one cycle per write |
| ioRead | input | 1 | Host read strobe; read data is valid in the same cycle |
| ioIsData | input | 1 | 1 selects the data port, 0 selects the address port |
| ioByteEn | input | 4 | Byte enables for writes |
| ioWrData | input | 32 | Host write data |
| ioRdData | output | 32 | Host read data; 0 when ioRead is low |
| evtParityErr | input | 1 | Parity error detected event |
| evtMasterAbortRx | input | 1 | Master abort received event |
| evtTargetAbortRx | input | 1 | Target abort received event |
| evtTargetAbortTx | input | 1 | Target abort signalled event |

## Verification
The assertions check four things on every cycle:
- the address latch only moves on an address-port write;
- each event flag is set the cycle after its event, whatever write happens at the same time;
- a flag stays set until a matching one is written;
- the fixed command bits and the subsystem value never move without the write that owns them.

Only the bench's scenarios can show the rest: the exact read values, the all-ones answer on a miss, byte-enable masking, and how the command bits behave across a test-bit toggle. The toggle case needs the stored values to reappear, and no single-cycle property can show that.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 6;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [REG_W-1:0] IDX_ID      = 6'h00;
  localparam logic [REG_W-1:0] IDX_CMDSTAT = 6'h01;
  localparam logic [REG_W-1:0] IDX_CLASS   = 6'h02;
  localparam logic [REG_W-1:0] IDX_HDR     = 6'h03;
  localparam logic [REG_W-1:0] IDX_SUBSYS  = 6'h0B;
  localparam logic [REG_W-1:0] IDX_ISA     = 6'h10;
  localparam logic [REG_W-1:0] IDX_TEST    = 6'h11;
  localparam logic [REG_W-1:0] IDX_SSALIAS = 6'h1C;

  localparam int FLAG_N = 4;
  localparam int TEST_BIT = 20;

  typedef struct packed {
    logic              wrEn;
    logic [REG_W-1:0]  regIdx;
    logic [BE_W-1:0]   byteEn;
  } cfgStrobe_t;
endpackage

// File: rtl/bridge_cfg_ctrl.sv
module bridge_cfg_ctrl
  import bridge_cfg_pkg::*;
#(
  parameter logic [BUS_W-1:0] BUS_NUM = '0,
  parameter logic [DEV_W-1:0] DEV_NUM = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrite,
  input  logic              ioRead,
  input  logic              ioIsData,
  input  logic [BE_W-1:0]   ioByteEn,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic [DATA_W-1:0] regRdData,
  output cfgStrobe_t        strobe,
  output logic [DATA_W-1:0] ioRdData
);
  logic              addrEn;
  logic [BUS_W-1:0]  addrBus;
  logic [DEV_W-1:0]  addrDev;
  logic [FUNC_W-1:0] addrFunc;
  logic [REG_W-1:0]  addrReg;
  logic [DATA_W-1:0] addrWord;
  logic              addrWr;
  logic              hit;
  logic              unusedAddrBits;

  assign unusedAddrBits = ^{ioWrData[30:24], ioWrData[1:0]};
  assign addrWr = ioWrite && !ioIsData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrEn   <= 1'b0;
      addrBus  <= '0;
      addrDev  <= '0;
      addrFunc <= '0;
      addrReg  <= '0;
    end else if (addrWr) begin
      if (ioByteEn[3]) addrEn <= ioWrData[31];
      if (ioByteEn[2]) addrBus <= ioWrData[23:16];
      if (ioByteEn[1]) begin
        addrDev  <= ioWrData[15:11];
        addrFunc <= ioWrData[10:8];
      end
      if (ioByteEn[0]) addrReg <= ioWrData[7:2];
    end
  end

  assign addrWord = {addrEn, 7'b0, addrBus, addrDev, addrFunc, addrReg, 2'b00};
  assign hit = addrEn && (addrBus == BUS_NUM) && (addrDev == DEV_NUM) && (addrFunc == '0);

  always_comb begin
    strobe.wrEn   = ioWrite && ioIsData && hit;
    strobe.regIdx = addrReg;
    strobe.byteEn = ioByteEn;
  end

  always_comb begin
    if (!ioRead)        ioRdData = '0;
    else if (!ioIsData) ioRdData = addrWord;
    else if (hit)       ioRdData = regRdData;
    else                ioRdData = '1;
  end

  // R1: the latch changes only on an address-port write
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !addrWr |=> $stable(addrWord));
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bridge_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID    = 16'h5E21,
  parameter logic [7:0]  REVISION_ID  = 8'h42,
  parameter logic [31:0] SUBSYS_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [FLAG_N-1:0] evt,
  output logic [DATA_W-1:0] regRdData
);
  localparam int FLAG_BIT [FLAG_N] = '{31, 29, 28, 27};

  logic              stepQ;
  logic              specCycQ;
  logic [1:0]        spaceEnQ;
  logic              testQ;
  logic [FLAG_N-1:0] flagQ;
  logic [7:0]        isaCtlQ;
  logic [7:0]        isaTestQ;
  logic [DATA_W-1:0] subsysQ;
  logic [15:0]       cmdWord;
  logic [15:0]       statWord;
  logic              cmdWr;
  logic              statusClr;
  logic              testWr;

  function automatic logic byteWr(input cfgStrobe_t s, input logic [REG_W-1:0] idx, input int b);
    return s.wrEn && (s.regIdx == idx) && s.byteEn[b];
  endfunction

  assign cmdWr     = byteWr(strobe, IDX_CMDSTAT, 0);
  assign statusClr = byteWr(strobe, IDX_CMDSTAT, 3);
  assign testWr    = byteWr(strobe, IDX_TEST, 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ    <= 1'b1;
      specCycQ <= 1'b0;
      spaceEnQ <= 2'b11;
    end else if (cmdWr) begin
      stepQ <= wrData[7];
      if (testQ) spaceEnQ <= wrData[1:0];
      else       specCycQ <= wrData[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       testQ <= 1'b0;
    else if (testWr) testQ <= wrData[TEST_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isaCtlQ  <= '0;
      isaTestQ <= '0;
    end else begin
      if (byteWr(strobe, IDX_ISA, 0)) isaCtlQ  <= wrData[7:0];
      if (byteWr(strobe, IDX_ISA, 1)) isaTestQ <= wrData[15:8];
    end
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_subsys
    always_ff @(posedge clk) begin
      if (!rstN)                            subsysQ[8*b +: 8] <= SUBSYS_RESET[8*b +: 8];
      else if (byteWr(strobe, IDX_SSALIAS, b)) subsysQ[8*b +: 8] <= wrData[8*b +: 8];
    end
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                                   flagQ[g] <= 1'b0;
      else if (evt[g])                             flagQ[g] <= 1'b1;
      else if (statusClr && wrData[FLAG_BIT[g]])   flagQ[g] <= 1'b0;
    end

    // R9: an event sets its flag even against a same-cycle clear
    assert_event_sets_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
      evt[g] |=> flagQ[g]);
    // R8: a flag only drops on a write of one to its bit
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
      flagQ[g] && !(statusClr && wrData[FLAG_BIT[g]]) |=> flagQ[g]);
  end

  always_comb begin
    cmdWord = 16'h0;
    cmdWord[7]   = stepQ;
    cmdWord[3]   = testQ ? 1'b1 : specCycQ;
    cmdWord[2]   = 1'b1;
    cmdWord[1:0] = testQ ? spaceEnQ : 2'b11;
    statWord = 16'h0;
    statWord[15]   = flagQ[0];
    statWord[13]   = flagQ[1];
    statWord[12]   = flagQ[2];
    statWord[11]   = flagQ[3];
    statWord[10:9] = 2'b01;
  end

  always_comb begin
    unique case (strobe.regIdx)
      IDX_ID:      regRdData = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTAT: regRdData = {statWord, cmdWord};
      IDX_CLASS:   regRdData = {8'h06, 8'h01, 8'h00, REVISION_ID};
      IDX_HDR:     regRdData = 32'h0080_0000;
      IDX_SUBSYS:  regRdData = subsysQ;
      IDX_ISA:     regRdData = {16'h0, isaTestQ, isaCtlQ};
      IDX_TEST:    regRdData = {11'h0, testQ, 20'h0};
      IDX_SSALIAS: regRdData = subsysQ;
      default:     regRdData = '0;
    endcase
  end

  // R5: in normal mode a command write leaves the space enables untouched
  assert_space_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !testQ |=> $stable(spaceEnQ));
  // R6: in test mode a command write leaves special-cycle storage untouched
  assert_speccyc_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && testQ |=> $stable(specCycQ));
  // R10: the subsystem value moves only through the alias dword
  assert_subsys_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.regIdx == IDX_SSALIAS) |=> $stable(subsysQ));
endmodule

// File: rtl/bridge_cfg_header.sv
module bridge_cfg_header
  import bridge_cfg_pkg::*;
#(
  parameter logic [7:0]  BUS_NUM      = 8'h00,
  parameter logic [4:0]  DEV_NUM      = 5'h07,
  parameter logic [15:0] VENDOR_ID    = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID    = 16'h5E21,
  parameter logic [7:0]  REVISION_ID  = 8'h42,
  parameter logic [31:0] SUBSYS_RESET = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWrite,
  input  logic        ioRead,
  input  logic        ioIsData,
  input  logic [3:0]  ioByteEn,
  input  logic [31:0] ioWrData,
  output logic [31:0] ioRdData,
  input  logic        evtParityErr,
  input  logic        evtMasterAbortRx,
  input  logic        evtTargetAbortRx,
  input  logic        evtTargetAbortTx
);
  cfgStrobe_t        strobe;
  logic [DATA_W-1:0] regRdData;
  logic [FLAG_N-1:0] evt;

  assign evt = {evtTargetAbortTx, evtTargetAbortRx, evtMasterAbortRx, evtParityErr};

  bridge_cfg_ctrl #(.BUS_NUM(BUS_NUM), .DEV_NUM(DEV_NUM)) ctrl_i (
    .clk(clk), .rstN(rstN), .ioWrite(ioWrite), .ioRead(ioRead), .ioIsData(ioIsData),
    .ioByteEn(ioByteEn), .ioWrData(ioWrData), .regRdData(regRdData),
    .strobe(strobe), .ioRdData(ioRdData)
  );

  bridge_cfg_regs #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION_ID(REVISION_ID), .SUBSYS_RESET(SUBSYS_RESET)
  ) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(ioWrData),
    .evt(evt), .regRdData(regRdData)
  );
endmodule

// File: tb/bridge_cfg_header_tb_top.sv
`timescale 1ns/1ps
module bridge_cfg_header_tb_top;
  localparam logic [7:0]  BUS = 8'h00;
  localparam logic [4:0]  DEV = 5'h07;
  localparam logic [15:0] VEN = 16'hA5C3;
  localparam logic [15:0] DID = 16'h5E21;
  localparam logic [7:0]  REV = 8'h42;

  logic clk = 0, rstN = 0;
  logic ioWrite = 0, ioRead = 0, ioIsData = 0;
  logic [3:0] ioByteEn = 0, evt = 0;
  logic [31:0] ioWrData = 0, ioRdData;
  int checks = 0, errors = 0;

  // reference state
  logic [31:0] mAddr;
  logic mStep, mSpc, mTest;
  logic [1:0] mLow;
  logic [3:0] mFlag;
  logic [7:0] m40, m41;
  logic [31:0] mSs;

  always #2.5 clk = ~clk;

  bridge_cfg_header dut_i (
    .clk(clk), .rstN(rstN), .ioWrite(ioWrite), .ioRead(ioRead), .ioIsData(ioIsData),
    .ioByteEn(ioByteEn), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .evtParityErr(evt[0]), .evtMasterAbortRx(evt[1]),
    .evtTargetAbortRx(evt[2]), .evtTargetAbortTx(evt[3])
  );

  function automatic bit mHit();
    return mAddr[31] && mAddr[23:16] == BUS && mAddr[15:11] == DEV && mAddr[10:8] == 3'd0;
  endfunction

  function automatic logic [31:0] expDword(input int idx);
    logic [15:0] c, s;
    c = {8'h0, mStep, 3'b0, mTest ? 1'b1 : mSpc, 1'b1, mTest ? mLow : 2'b11};
    s = {mFlag[0], 1'b0, mFlag[1], mFlag[2], mFlag[3], 2'b01, 9'h0};
    case (idx)
      'h00: return {DID, VEN};
      'h01: return {s, c};
      'h02: return {8'h06, 8'h01, 8'h00, REV};
      'h03: return 32'h0080_0000;
      'h0B, 'h1C: return mSs;
      'h10: return {16'h0, m41, m40};
      'h11: return {11'h0, mTest, 20'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(input bit isData, input logic [3:0] be, input logic [31:0] d);
    if (!isData) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mAddr[8*b +: 8] = d[8*b +: 8] & (32'h80FF_FFFC >> (8*b));
    end else if (mHit()) begin
      case (int'(mAddr[7:2]))
        'h01: begin
          if (be[0]) begin
            mStep = d[7];
            if (mTest) mLow = d[1:0]; else mSpc = d[3];
          end
          if (be[3]) begin
            if (d[31]) mFlag[0] = 0;
            if (d[29]) mFlag[1] = 0;
            if (d[28]) mFlag[2] = 0;
            if (d[27]) mFlag[3] = 0;
          end
        end
        'h10: begin
          if (be[0]) m40 = d[7:0];
          if (be[1]) m41 = d[15:8];
        end
        'h11: if (be[2]) mTest = d[20];
        'h1C: for (int b = 0; b < 4; b++) if (be[b]) mSs[8*b +: 8] = d[8*b +: 8];
        default: ;
      endcase
    end
  endtask

  task automatic ioWr(input bit isData, input logic [3:0] be, input logic [31:0] d,
                      input logic [3:0] ev = 4'h0);
    @(negedge clk);
    ioWrite = 1; ioIsData = isData; ioByteEn = be; ioWrData = d; evt = ev;
    @(posedge clk); #1;
    ioWrite = 0; evt = 0;
    modelWrite(isData, be, d);
    mFlag = mFlag | ev;
  endtask

  task automatic rdChk(input bit isData, input logic [31:0] exp, input string tag);
    @(negedge clk);
    ioRead = 1; ioIsData = isData;
    #1;
    checks++;
    if (ioRdData !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, ioRdData, exp);
    end
    ioRead = 0;
  endtask

  task automatic selectReg(input int idx);
    ioWr(0, 4'hF, {1'b1, 7'b0, BUS, DEV, 3'b0, 6'(idx), 2'b00});
  endtask

  task automatic chkReg(input int idx, input string tag);
    selectReg(idx);
    rdChk(1, expDword(idx), tag);
  endtask

  task automatic cfgWr(input int idx, input logic [3:0] be, input logic [31:0] d);
    selectReg(idx);
    ioWr(1, be, d);
  endtask

  task automatic pulseEvt(input logic [3:0] ev);
    @(negedge clk); evt = ev;
    @(posedge clk); #1; evt = 0;
    mFlag = mFlag | ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mAddr = 0; mStep = 1; mSpc = 0; mTest = 0; mLow = 2'b11; mFlag = 0;
    m40 = 0; m41 = 0; mSs = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // reset state
    rdChk(0, 32'h0, "R1 latch reset");
    chkReg('h00, "R3 ids");
    chkReg('h01, "R4 R7 command/status reset");
    chkReg('h02, "R3 class");
    chkReg('h03, "R3 header type");
    chkReg('h0B, "R10 subsystem reset");
    chkReg('h10, "R11 isa reset");
    chkReg('h11, "R12 test reset");
    chkReg('h05, "R13 unimplemented");

    // address port
    ioWr(0, 4'hF, 32'hFFFF_FFFF);
    rdChk(0, mAddr, "R1 reserved bits read 0");
    ioWr(0, 4'h1, 32'h0);
    rdChk(0, mAddr, "R1 byte-enabled latch write");
    ioWr(0, 4'hF, {1'b1, 7'b0, BUS, 5'h03, 3'b0, 6'h10, 2'b00});
    rdChk(1, 32'hFFFF_FFFF, "R2 device miss reads ones");
    ioWr(1, 4'hF, 32'hFFFF_FFFF);
    ioWr(0, 4'hF, {1'b1, 7'b0, BUS, DEV, 3'd1, 6'h10, 2'b00});
    rdChk(1, 32'hFFFF_FFFF, "R2 function miss reads ones");
    ioWr(1, 4'hF, 32'hFFFF_FFFF);
    ioWr(0, 4'hF, {1'b0, 7'b0, BUS, DEV, 3'd0, 6'h10, 2'b00});
    rdChk(1, 32'hFFFF_FFFF, "R2 disabled reads ones");
    ioWr(1, 4'hF, 32'hFFFF_FFFF);
    chkReg('h10, "R2 missed writes ignored");

    // read-only identification
    cfgWr('h00, 4'hF, 32'h0);
    chkReg('h00, "R3 id write ignored");
    cfgWr('h03, 4'hF, 32'hFFFF_FFFF);
    chkReg('h03, "R3 header write ignored");

    // command, normal mode
    cfgWr('h01, 4'h1, 32'h0000_00FF);
    chkReg('h01, "R5 special cycle set, bits 1:0 fixed");
    cfgWr('h01, 4'h1, 32'h0000_0000);
    chkReg('h01, "R4 stepping cleared");
    cfgWr('h01, 4'h1, 32'h0000_0008);

    // test mode
    cfgWr('h11, 4'h3, 32'h0010_0000);
    chkReg('h11, "R11 disabled byte not written");
    cfgWr('h11, 4'h4, 32'h0010_0000);
    chkReg('h01, "R6 bit 3 reads one");
    cfgWr('h01, 4'h1, 32'h0000_0080);
    chkReg('h01, "R6 bits 1:0 writable");
    cfgWr('h11, 4'h4, 32'h0);
    chkReg('h01, "R5 normal mode restored");
    cfgWr('h11, 4'h4, 32'h0010_0000);
    chkReg('h01, "R6 stored bits reappear");
    cfgWr('h11, 4'h4, 32'h0);

    // status flags
    pulseEvt(4'b0010);
    chkReg('h01, "R8 master abort set");
    pulseEvt(4'b1101);
    chkReg('h01, "R8 other flags set");
    cfgWr('h01, 4'h8, 32'h2000_0000);
    chkReg('h01, "R8 w1c one flag");
    cfgWr('h01, 4'h8, 32'h0);
    chkReg('h01, "R8 write zero keeps");
    cfgWr('h01, 4'h7, 32'hFFFF_FFFF);
    chkReg('h01, "R11 clear needs byte enable 3");
    selectReg('h01);
    ioWr(1, 4'h8, 32'h8000_0000, 4'b0001);
    rdChk(1, expDword('h01), "R9 set beats clear");
    cfgWr('h01, 4'h8, 32'hFFFF_FFFF);
    chkReg('h01, "R7 fixed status bits");

    // subsystem
    cfgWr('h0B, 4'hF, 32'h1234_5678);
    chkReg('h0B, "R10 read-only at 2Ch");
    cfgWr('h1C, 4'h5, 32'hDEAD_BEEF);
    chkReg('h0B, "R10 alias sets value");
    chkReg('h1C, "R10 alias reads value");

    // ISA bytes and test dword
    cfgWr('h10, 4'hF, 32'hFFFF_FFFF);
    chkReg('h10, "R11 isa bytes writable");
    cfgWr('h10, 4'h2, 32'h0);
    chkReg('h10, "R11 byte enable mask");
    cfgWr('h11, 4'hF, 32'hFFFF_FFFF);
    chkReg('h11, "R12 only test bit stored");
    cfgWr('h11, 4'hF, 32'h0);
    cfgWr('h3F, 4'hF, 32'hFFFF_FFFF);
    chkReg('h3F, "R13 unimplemented stays 0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule